// File: doc/BRIEF.md
# Tilt Bubble-Level LED Mapper

This block turns a pair of signed acceleration samples into a "bubble level" picture on a bar of eight LEDs. Each axis is divided down by an arithmetic right shift. The scaled value is sorted into one of four coarse positions, and that position is shown as a single lit LED inside a four-LED group. The X axis fills the lower group of four LEDs and the Y axis fills the upper group. The scaled value is clamped at both ends, so a reading of any size still lands on an outer LED.

The output is registered. A new pattern is captured only on a clock edge where the sample-valid strobe is high. Between strobes the pattern holds, so an upstream sensor reader can present samples at any rate. The shift parameter sets the sensitivity. A small shift lets small tilts reach the outer LEDs. A large shift needs a much larger reading before the pointer moves off centre.

Top module: `tilt_led_mapper`

## Requirements
- R1: While `rst_n` is low, `led` is 8'h44: bit 2 of each nibble is lit. This holds even if `sample_valid` is high during reset.
- R2: Each axis is scaled by an arithmetic right shift of `SHIFT` bits (default 6). The shift rounds toward negative infinity, so -1 and -64 both scale to -1 when the default is used.
- R3: Out of reset, exactly one bit of `led[3:0]` and exactly one bit of `led[7:4]` is set at all times.
- R4: Each scaled value sets one bit of its nibble:
  - less than -1 sets bit 0;
  - exactly -1 sets bit 1;
  - exactly 0 sets bit 2;
  - greater than 0 sets bit 3.
- R5: The extreme inputs peg the outer LEDs. The most negative input (-32768) sets bit 0 and the most positive input (32767) sets bit 3.
- R6: `led[3:0]` depends only on `accel_x` and `led[7:4]` depends only on `accel_y`.
- R7: A sample presented with `sample_valid` high at a rising clock edge appears on `led` right after that edge. `led` does not change before that edge.
- R8: While `sample_valid` is low, `led` holds its last value whatever `accel_x` and `accel_y` do.
- R9: `SHIFT` sets the thresholds. Bit 3 is set when the sample is at least 2^SHIFT. Bit 0 is set when the sample is at most -(2^SHIFT)-1. With `SHIFT` = 2, a sample of 4 sets bit 3, while the default shift maps the same sample to bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe that marks a new X/Y pair for capture |
| accel_x | input | 16 | Signed X-axis sample |
| accel_y | input | 16 | Signed Y-axis sample |
| led | output | 8 | One-hot X pointer in [3:0], one-hot Y pointer in [7:4] |

## Verification
The bench drives samples on both sides of every bucket edge: 63/64, 0/-1 and -64/-65. A design that used a truncating divide instead of an arithmetic shift would place -1 and -65 in the wrong buckets. The full-scale values check that no wrap-around pulls a pegged reading back toward the centre. Opposing X and Y values catch swapped or crossed nibbles. Changing the samples while the strobe is low catches a register that follows its input. A second instance with a small shift shows that the thresholds really follow the parameter and are not fixed at the default.

// File: rtl/tilt_pkg.sv
package tilt_pkg;

  // Number of pointer positions per axis; fixed at four by the display.
  localparam int BUCKETS  = 4;
  localparam int BUCKET_W = $clog2(BUCKETS);
  localparam int NIBBLE_W = BUCKETS;

  typedef logic [BUCKET_W-1:0] bucket_t;
  typedef logic [NIBBLE_W-1:0] nibble_t;

  localparam bucket_t BKT_FAR_NEG  = 2'd0;
  localparam bucket_t BKT_NEAR_NEG = 2'd1;
  localparam bucket_t BKT_CENTRE   = 2'd2;
  localparam bucket_t BKT_POS      = 2'd3;

  // Classify a scaled value from three width-independent flags:
  // its sign, whether it is all ones (-1) and whether it is all zeros.
  function automatic bucket_t classify(input logic is_neg,
                                       input logic is_minus_one,
                                       input logic is_zero);
    bucket_t b;
    if (is_minus_one)      b = BKT_NEAR_NEG;
    else if (is_neg)       b = BKT_FAR_NEG;
    else if (is_zero)      b = BKT_CENTRE;
    else                   b = BKT_POS;
    return b;
  endfunction

  // Pattern shown on each nibble after reset.
  function automatic nibble_t reset_nibble();
    nibble_t n;
    n = '0;
    n[BKT_CENTRE] = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/tilt_axis_quant.sv
module tilt_axis_quant
  import tilt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHIFT    = 6   // must be below SAMPLE_W
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SAMPLE_W-1:0] scaled,
  output bucket_t                    bucket
);

  logic is_neg;
  logic is_minus_one;
  logic is_zero;

  assign scaled       = sample >>> SHIFT;
  assign is_neg       = scaled[SAMPLE_W-1];
  assign is_minus_one = &scaled;
  assign is_zero      = ~|scaled;
  assign bucket       = classify(is_neg, is_minus_one, is_zero);

endmodule

// File: rtl/tilt_onehot.sv
module tilt_onehot #(
  parameter int N = 4
) (
  input  logic [$clog2(N)-1:0] code,
  output logic [N-1:0]         hot
);

  localparam int CODE_W = $clog2(N);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = (code == CODE_W'(i));
  end

endmodule

// File: rtl/tilt_led_mapper.sv
module tilt_led_mapper
  import tilt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHIFT    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] accel_x,
  input  logic [SAMPLE_W-1:0] accel_y,
  output logic [7:0]          led
);

  localparam int AXES  = 2;
  localparam int LED_W = AXES * NIBBLE_W;

  logic signed [SAMPLE_W-1:0] axis_sample [AXES];
  logic signed [SAMPLE_W-1:0] axis_scaled [AXES];
  bucket_t                    axis_bucket [AXES];
  logic [LED_W-1:0]           led_next;
  logic [LED_W-1:0]           led_q;
  logic                       capture;

  // Axis 0 is X (low nibble), axis 1 is Y (high nibble).
  assign axis_sample[0] = $signed(accel_x);
  assign axis_sample[1] = $signed(accel_y);

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    tilt_axis_quant #(
      .SAMPLE_W (SAMPLE_W),
      .SHIFT    (SHIFT)
    ) u_quant (
      .sample (axis_sample[a]),
      .scaled (axis_scaled[a]),
      .bucket (axis_bucket[a])
    );

    tilt_onehot #(
      .N (BUCKETS)
    ) u_hot (
      .code (axis_bucket[a]),
      .hot  (led_next[a*NIBBLE_W +: NIBBLE_W])
    );
  end

  assign capture = sample_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       led_q <= {AXES{reset_nibble()}};
    else if (capture) led_q <= led_next;
  end

  assign led = led_q;

endmodule

// File: rtl/tilt_led_mapper_chk.sv
module tilt_led_mapper_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_valid,
  input logic [SAMPLE_W-1:0] accel_x,
  input logic [SAMPLE_W-1:0] accel_y,
  input logic [7:0]          led
);

  localparam logic [SAMPLE_W-1:0] MAX_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] MAX_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  AST_RESET_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> led == 8'h44) else $error("reset pattern"); // R1

  AST_ONE_LED_PER_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(led[3:0]) == 1) && ($countones(led[7:4]) == 1)) else $error("one-hot"); // R3

  AST_X_SIGN_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && accel_x[SAMPLE_W-1] |=> led[1:0] != 2'b00) else $error("x sign"); // R4

  AST_Y_SIGN_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !accel_y[SAMPLE_W-1] |=> led[7:6] != 2'b00) else $error("y sign"); // R6

  AST_PEG_POS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && accel_x == MAX_POS |=> led[3]) else $error("peg pos"); // R5

  AST_PEG_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && accel_y == MAX_NEG |=> led[4]) else $error("peg neg"); // R5

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(led)) else $error("hold"); // R8

endmodule

bind tilt_led_mapper tilt_led_mapper_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .accel_x      (accel_x),
  .accel_y      (accel_y),
  .led          (led)
);

// File: tb/tilt_led_mapper_tb.sv
`timescale 1ns/1ps
module tilt_led_mapper_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [15:0] accel_x = '0;
  logic [15:0] accel_y = '0;
  logic [7:0]  led;
  logic [7:0]  led_s2;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tilt_led_mapper u_dut (
    .clk (clk), .rst_n (rst_n), .sample_valid (sample_valid),
    .accel_x (accel_x), .accel_y (accel_y), .led (led)
  );

  tilt_led_mapper #(.SHIFT(2)) u_dut_s2 (
    .clk (clk), .rst_n (rst_n), .sample_valid (sample_valid),
    .accel_x (accel_x), .accel_y (accel_y), .led (led_s2)
  );

  // Expected nibble from thresholds: >= 2^s, >= 0, >= -2^s, else.
  function automatic logic [3:0] exp_nib(int v, int s);
    int lim = 1 << s;
    if (v >= lim)       return 4'b1000;
    else if (v >= 0)    return 4'b0100;
    else if (v >= -lim) return 4'b0010;
    else                return 4'b0001;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: led=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one pair with the strobe, then check both instances.
  task automatic apply(string req, int x, int y);
    @(negedge clk);
    accel_x = 16'(x);
    accel_y = 16'(y);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    check(req, led, {exp_nib(y, 6), exp_nib(x, 6)});
    check({req, " (R9 shift2)"}, led_s2, {exp_nib(y, 2), exp_nib(x, 2)});
    check({req, " R3"}, 8'(($countones(led[3:0]) == 1) && ($countones(led[7:4]) == 1)), 8'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sample_valid = 1'b1;
    accel_x = 16'h7fff;
    accel_y = 16'h8000;
    repeat (3) @(negedge clk);
    check("R1 reset", led, 8'h44);
    check("R1 reset shift2", led_s2, 8'h44);
    sample_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", led, 8'h44);
  endtask

  task automatic t_buckets();
    apply("R4 zero", 0, 0);
    apply("R2 R4 edge 63/64", 63, 64);
    apply("R2 R4 minus one", -1, -64);
    apply("R2 R4 edge -65", -65, -64);
    apply("R4 mid", 100, -100);
    apply("R9 small positive", 4, 3);
    apply("R9 small negative", -5, -4);
  endtask

  task automatic t_extremes();
    apply("R5 peg", 32767, -32768);
    apply("R5 peg swapped", -32768, 32767);
  endtask

  task automatic t_axes();
    apply("R6 x only", 5000, 0);
    apply("R6 y only", 0, -5000);
  endtask

  task automatic t_timing();
    apply("R7 preset", 0, 0);
    @(negedge clk);
    accel_x = 16'd1000;
    accel_y = 16'hfc18;
    sample_valid = 1'b1;
    #1;
    check("R7 before edge", led, 8'h44);
    @(negedge clk);
    sample_valid = 1'b0;
    check("R7 after edge", led, 8'h18);
  endtask

  task automatic t_hold();
    apply("R8 preset", 200, -200);
    @(negedge clk);
    accel_x = 16'h8000;
    accel_y = 16'h7fff;
    repeat (3) @(negedge clk);
    check("R8 hold", led, 8'h18);
    check("R8 hold shift2", led_s2, 8'h18);
  endtask

  initial begin
    t_reset();
    t_buckets();
    t_extremes();
    t_axes();
    t_timing();
    t_hold();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      nvec++;
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule